// File: doc/BRIEF.md
# Serial Port Interrupt Resolver

This block holds the pending interrupt causes of a 16550-style serial port and turns them, each cycle, into one interrupt request line and a 4-bit identification code. The register front end of the port feeds it single-cycle strobes:

- a byte arrived in the receive queue;
- the receive queue was emptied;
- software wrote a transmit byte;
- software read the identification register;
- software wrote the interrupt-enable register.

The front end also supplies the current enable mask, the FIFO-enable bit and a level that says a modem-status change is waiting.

Three causes are stored inside the block: character timeout, receive data and transmit-holding empty. The modem cause is taken as a live level. The code shown is that of the highest-priority cause whose enable bit is set. The order, from highest, is character timeout, receive data, transmit empty, modem status. One enable bit serves both receive causes. Reading the identification register retires only the transmit-empty cause. Turning its enable bit back on arms that cause again, so software that masked it is told again that the holding register is free.

Top module: `uart_irq_resolver`

## Requirements
- R1: After reset the code is 0x1 and the request is low, and transmit empty is already pending: setting enable bit 1 alone then shows code 0x2.
- R2: When several enabled causes are pending, the code is that of the highest one. The order from highest is character timeout (0xC), receive data (0x4), transmit empty (0x2), modem status (0x0). The code is 0x1 when no enabled cause is pending.
- R3: A received-byte strobe marks character timeout pending when the FIFO-enable input is 1, and receive data pending when it is 0.
- R4: A queue-drained strobe clears both the character-timeout and the receive-data pending state.
- R5: A transmit-write strobe marks transmit empty pending.
- R6: An identification-read strobe clears transmit empty only while the code shown is 0x2. A read while any other code is shown leaves every cause untouched.
- R7: An enable write whose data has bit 1 set, made while mask bit 1 is 0, marks transmit empty pending again.
- R8: The request output is high exactly when the code differs from 0x1.
- R9: When a cause is set and cleared in the same cycle, it ends up pending.
- R10: The modem level gives code 0x0 when mask bit 3 is set and no higher enabled cause is pending.
- R11: Mask bit 0 gates both receive causes, and mask bit 1 gates transmit empty. A masked cause keeps its pending state and appears once its bit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_evt | input | 1 | Strobe: a byte entered the receive queue |
| rx_drain_evt | input | 1 | Strobe: the receive queue became empty |
| tx_write_evt | input | 1 | Strobe: a transmit byte was written |
| iid_read_evt | input | 1 | Strobe: the identification register was read |
| ier_wr_evt | input | 1 | Strobe: the enable register is being written |
| ier_wdata | input | 4 | Data of that enable write |
| ier_mask | input | 4 | Current enable mask: bit 0 receive, bit 1 transmit, bit 3 modem |
| fifo_en | input | 1 | FIFO-enable bit of the FIFO control register |
| msr_delta | input | 1 | Level: a modem-status change is waiting |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Identification code |

## Verification
Two pairs of functions can land in the same cycle: an identification read that retires transmit empty together with a transmit write that sets it, and a received byte together with a queue drain. Directed cycles drive each pair at once and expect the cause to remain pending. The random phase also raises these strobes together often, and each cycle it compares the code with a bench model in which a set always overrides a clear.

// File: rtl/uart_irq_resolver.sv
module uart_irq_resolver (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_byte_evt,
  input  logic       rx_drain_evt,
  input  logic       tx_write_evt,
  input  logic       iid_read_evt,
  input  logic       ier_wr_evt,
  input  logic [3:0] ier_wdata,
  input  logic [3:0] ier_mask,
  input  logic       fifo_en,
  input  logic       msr_delta,
  output logic       irq,
  output logic [3:0] iid
);
  localparam logic [3:0] CodeTimeout = 4'hC;
  localparam logic [3:0] CodeRxData  = 4'h4;
  localparam logic [3:0] CodeTxEmpty = 4'h2;
  localparam logic [3:0] CodeModem   = 4'h0;
  localparam logic [3:0] CodeNone    = 4'h1;

  logic to_pend, rx_pend, tx_pend;
  logic to_set, rx_set, tx_set, tx_clr, rearm;

  assign rearm  = ier_wr_evt && ier_wdata[1] && !ier_mask[1];
  assign to_set = rx_byte_evt && fifo_en;
  assign rx_set = rx_byte_evt && !fifo_en;
  assign tx_set = tx_write_evt || rearm;
  assign tx_clr = iid_read_evt && (iid == CodeTxEmpty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_pend <= 1'b0;
      rx_pend <= 1'b0;
      tx_pend <= 1'b1;
    end else begin
      to_pend <= to_set || (to_pend && !rx_drain_evt);
      rx_pend <= rx_set || (rx_pend && !rx_drain_evt);
      tx_pend <= tx_set || (tx_pend && !tx_clr);
    end
  end

  always_comb begin
    if (to_pend && ier_mask[0])        iid = CodeTimeout;
    else if (rx_pend && ier_mask[0])   iid = CodeRxData;
    else if (tx_pend && ier_mask[1])   iid = CodeTxEmpty;
    else if (msr_delta && ier_mask[3]) iid = CodeModem;
    else                               iid = CodeNone;
  end

  assign irq = (iid != CodeNone);
endmodule

module uart_irq_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_byte_evt,
  input logic       rx_drain_evt,
  input logic       tx_write_evt,
  input logic       iid_read_evt,
  input logic       ier_wr_evt,
  input logic [3:0] ier_wdata,
  input logic [3:0] ier_mask,
  input logic       fifo_en,
  input logic       msr_delta,
  input logic       irq,
  input logic [3:0] iid
);
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iid == 4'hC || iid == 4'h4 || iid == 4'h2 || iid == 4'h0 || iid == 4'h1));

  p_timeout_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_evt && fifo_en) |=> (!ier_mask[0] || iid == 4'hC));

  p_rxdata_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_evt && !fifo_en) |=> (!ier_mask[0] || iid == 4'hC || iid == 4'h4));

  p_drain_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drain_evt && !rx_byte_evt) |=> (iid != 4'hC && iid != 4'h4));

  p_tx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write_evt |=> (!ier_mask[1] || iid == 4'hC || iid == 4'h4 || iid == 4'h2));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_read_evt && iid == 4'h2 && !tx_write_evt &&
     !(ier_wr_evt && ier_wdata[1] && !ier_mask[1])) |=> (iid != 4'h2));

  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr_evt && ier_wdata[1] && !ier_mask[1]) |=>
      (!ier_mask[1] || iid == 4'hC || iid == 4'h4 || iid == 4'h2));

  p_modem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_delta && ier_mask[3]) |-> irq);
endmodule

bind uart_irq_resolver uart_irq_resolver_chk u_chk (.*);

// File: tb/uart_irq_resolver_tb.sv
`timescale 1ns/1ps
module uart_irq_resolver_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_byte_evt = 0, rx_drain_evt = 0, tx_write_evt = 0, iid_read_evt = 0;
  logic ier_wr_evt = 0, fifo_en = 0, msr_delta = 0;
  logic [3:0] ier_wdata = 0, ier_mask = 0;
  logic irq;
  logic [3:0] iid;
  int checks = 0, fails = 0;
  bit m_to, m_rx, m_tx;

  always #2.5 clk = ~clk;

  uart_irq_resolver u_dut (.*);

  function automatic logic [3:0] exp_code(bit t, bit r, bit x, logic [3:0] m, bit d);
    if (t && m[0]) return 4'hC;
    if (r && m[0]) return 4'h4;
    if (x && m[1]) return 4'h2;
    if (d && m[3]) return 4'h0;
    return 4'h1;
  endfunction

  task automatic check(string tag);
    logic [3:0] e;
    e = exp_code(m_to, m_rx, m_tx, ier_mask, msr_delta);
    checks++;
    if (iid !== e || irq !== (e != 4'h1)) begin
      fails++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b", tag, iid, irq, e, e != 4'h1);
    end
  endtask

  task automatic step(string tag);
    logic [3:0] cur;
    bit rearm;
    @(posedge clk);
    cur = exp_code(m_to, m_rx, m_tx, ier_mask, msr_delta);
    rearm = ier_wr_evt && ier_wdata[1] && !ier_mask[1];
    m_to = (rx_byte_evt && fifo_en) || (m_to && !rx_drain_evt);
    m_rx = (rx_byte_evt && !fifo_en) || (m_rx && !rx_drain_evt);
    m_tx = tx_write_evt || rearm || (m_tx && !(iid_read_evt && cur == 4'h2));
    #1;
    check(tag);
    @(negedge clk);
    if (ier_wr_evt) ier_mask = ier_wdata;
    {rx_byte_evt, rx_drain_evt, tx_write_evt, iid_read_evt, ier_wr_evt} = '0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_to = 0; m_rx = 0; m_tx = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset code");
    ier_mask = 4'b0010; #1; check("R1 tx pending after reset");
    iid_read_evt = 1; step("R6 read clears tx");
    iid_read_evt = 1; step("R6 read with code 1 no effect");
    ier_mask = 4'b0000; step("R11 masked idle");
    ier_wr_evt = 1; ier_wdata = 4'b0010; step("R7 rearm tx");
    tx_write_evt = 1; step("R5 tx write");
    iid_read_evt = 1; tx_write_evt = 1; step("R9 read and write same cycle");
    ier_mask = 4'b1011; msr_delta = 1;
    fifo_en = 0; rx_byte_evt = 1; step("R3 rx data");
    fifo_en = 1; rx_byte_evt = 1; step("R2 timeout over rx data");
    iid_read_evt = 1; step("R6 read with code C keeps tx");
    ier_mask = 4'b1010; #1; check("R11 receive masked, tx shown");
    ier_mask = 4'b1011; #1; check("R11 receive reappears");
    rx_byte_evt = 1; rx_drain_evt = 1; step("R9 byte and drain same cycle");
    rx_drain_evt = 1; step("R4 drain clears receive");
    iid_read_evt = 1; step("R10 modem after tx read");
    msr_delta = 0; #1; check("R8 idle request low");
    for (int i = 0; i < 4000; i++) begin
      rx_byte_evt  = ($urandom % 5) == 0;
      rx_drain_evt = ($urandom % 6) == 0;
      tx_write_evt = ($urandom % 5) == 0;
      iid_read_evt = ($urandom % 3) == 0;
      ier_wr_evt   = ($urandom % 8) == 0;
      ier_wdata    = 4'($urandom) & 4'b1011;
      fifo_en      = $urandom % 2;
      msr_delta    = ($urandom % 4) == 0;
      step("R2 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule